// File: doc/BRIEF.md
# Scatter Descriptor Table Generator

This block turns a request made of buffer segments into a descriptor table for a bus-master DMA engine. Each segment is a 32-bit bus address and a byte length, and segments arrive one at a time on a valid/ready handshake that has a last flag. When a segment starts exactly where the open region ends, the block merges it into that region. Every region is then cut into descriptors, and no descriptor crosses a 64 KB address boundary.

Each descriptor takes two 32-bit words in a local table memory. The block writes these words in order, starting at word address 0. When the request ends, the block rewrites the last count word with its end-of-table bit set. It then raises `done` for one cycle and shows the number of entries.

The block raises `fail` instead, with a reason code, in three cases: a segment is misaligned, the table would overflow, or the request is empty. In each case the host moves the data with programmed I/O instead.

Top module: `sg_table_gen`

## Requirements
- R1: For descriptor k, the block writes the chunk base address to word 2k and then `{16'h0, length[15:0]}` to word 2k+1. Word writes run in order from address 0.
- R2: A segment whose address equals the open region's address plus its accumulated size is merged into that region. Merging writes no descriptor of its own.
- R3: Each chunk is min(remaining size, 0x10000 − address[15:0]), so no descriptor crosses a 64 KB boundary.
- R4: A chunk of exactly 64 KB is written with a count field of zero.
- R5: After the last segment, the block rewrites the last count word with bit 31 set. No other word has bit 31 set.
- R6: A segment whose address has bit 1 or bit 0 set fails the request with `failCode` = 1. No descriptor is written for that segment.
- R7: With TABLE_ENTRIES = C, a request that needs C or more descriptors fails with `failCode` = 2. At most C−1 entries are ever written.
- R8: A request whose total size is zero fails with `failCode` = 3 and does not assert `done`.
- R9: On success, `done` is high for exactly one cycle, `entryCount` shows the number of descriptors, and `fail` stays low.
- R10: `done` or `fail` is reported only after the last segment has been accepted. After a failure, the block accepts and discards the rest of the request and is then ready for a new request.
- R11: A segment is consumed only in a cycle where `segValid` and `segReady` are both high, and each segment is consumed exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segValid | input | 1 | A segment is offered |
| segReady | output | 1 | The block takes the offered segment this cycle |
| segAddr | input | 32 | Segment bus address |
| segLen | input | LEN_W | Segment length in bytes |
| segLast | input | 1 | This is the final segment of the request |
| memWe | output | 1 | Table word write strobe |
| memAddr | output | CNT_W+1 | Table word address |
| memData | output | 32 | Table word data |
| done | output | 1 | One-cycle pulse: table complete |
| entryCount | output | CNT_W | Descriptor count, valid while `done` is high |
| fail | output | 1 | One-cycle pulse: request rejected |
| failCode | output | 2 | 1 misaligned, 2 overflow, 3 empty; valid while `fail` is high |

## Verification
The checker assumes three things about the inputs:
- A segment stays stable while `segValid` is high and `segReady` is low.
- Segment lengths fit in LEN_W bits.
- A merged region's address plus its size never wraps past 2^32.

The bench drives segments only from a task that holds each one until the handshake completes. It keeps addresses and lengths well below the wrap point, so the 64 KB boundary rule and the strict word ordering can be checked from the table writes alone.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    S_ACCEPT, S_EMIT_A, S_EMIT_C, S_EOT, S_DONE, S_FAIL, S_DRAIN
  } sg_state_t;

  typedef struct packed {
    logic takeSeg;
    logic savePend;
    logic loadPend;
    logic wrAddr;
    logic wrCount;
    logic wrEot;
    logic clearAll;
  } sg_strobe_t;

  typedef struct packed {
    logic misaligned;
    logic contiguous;
    logic haveRegion;
    logic regEmpty;
    logic atCapacity;
    logic countZero;
    logic pendLast;
  } sg_status_t;

  localparam logic [1:0] FAIL_MISALIGN = 2'd1;
  localparam logic [1:0] FAIL_OVERFLOW = 2'd2;
  localparam logic [1:0] FAIL_EMPTY    = 2'd3;
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       segValid,
  input  logic       segLast,
  input  sg_status_t st,
  output sg_strobe_t stb,
  output logic       segReady,
  output logic       done,
  output logic       fail,
  output logic [1:0] failCode
);
  sg_state_t state, nextState;
  logic finalReg, nextFinal, lastSeen, nextLastSeen;
  logic [1:0] codeReg, nextCode;

  always_comb begin
    stb          = '0;
    nextState    = state;
    nextFinal    = finalReg;
    nextLastSeen = lastSeen;
    nextCode     = codeReg;
    segReady     = 1'b0;
    unique case (state)
      S_ACCEPT: begin
        segReady = 1'b1;
        if (segValid) begin
          if (segLast) nextLastSeen = 1'b1;
          if (st.misaligned) begin
            nextCode  = FAIL_MISALIGN;
            nextState = segLast ? S_FAIL : S_DRAIN;
          end else if (!st.haveRegion || st.contiguous) begin
            stb.takeSeg = 1'b1;
            if (segLast) begin
              nextFinal = 1'b1;
              nextState = S_EMIT_A;
            end
          end else begin
            stb.savePend = 1'b1;
            nextState    = S_EMIT_A;
          end
        end
      end
      S_EMIT_A: begin
        if (st.regEmpty) begin
          if (finalReg) begin
            if (st.countZero) begin
              nextCode  = FAIL_EMPTY;
              nextState = S_FAIL;
            end else begin
              nextState = S_EOT;
            end
          end else begin
            stb.loadPend = 1'b1;
            nextFinal    = st.pendLast;
            nextState    = st.pendLast ? S_EMIT_A : S_ACCEPT;
          end
        end else if (st.atCapacity) begin
          nextCode  = FAIL_OVERFLOW;
          nextState = lastSeen ? S_FAIL : S_DRAIN;
        end else begin
          stb.wrAddr = 1'b1;
          nextState  = S_EMIT_C;
        end
      end
      S_EMIT_C: begin
        stb.wrCount = 1'b1;
        nextState   = S_EMIT_A;
      end
      S_EOT: begin
        stb.wrEot = 1'b1;
        nextState = S_DONE;
      end
      S_DRAIN: begin
        segReady = 1'b1;
        if (segValid && segLast) nextState = S_FAIL;
      end
      S_DONE, S_FAIL: begin
        stb.clearAll = 1'b1;
        nextFinal    = 1'b0;
        nextLastSeen = 1'b0;
        nextState    = S_ACCEPT;
      end
      default: nextState = S_ACCEPT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_ACCEPT;
      finalReg <= 1'b0;
      lastSeen <= 1'b0;
      codeReg  <= 2'd0;
    end else begin
      state    <= nextState;
      finalReg <= nextFinal;
      lastSeen <= nextLastSeen;
      codeReg  <= nextCode;
    end
  end

  assign done     = (state == S_DONE);
  assign fail     = (state == S_FAIL);
  assign failCode = codeReg;
endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CAP   = 256,
  parameter int CNT_W = $clog2(CAP),
  parameter int AW    = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sg_strobe_t       stb,
  input  logic [31:0]      segAddr,
  input  logic [LEN_W-1:0] segLen,
  input  logic             segLast,
  output sg_status_t       st,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memData,
  output logic [CNT_W-1:0] entryCount
);
  logic [31:0] regAddr, regSize, pendAddr, pendLen, segLen32;
  logic        haveRegion, pendLast;
  logic [CNT_W-1:0] count;
  logic [15:0] lastCnt;
  logic [16:0] room, chunk;

  assign segLen32 = 32'(segLen);
  assign room     = 17'h10000 - {1'b0, regAddr[15:0]};
  assign chunk    = (regSize < {15'd0, room}) ? regSize[16:0] : room;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      regAddr    <= '0;
      regSize    <= '0;
      haveRegion <= 1'b0;
      pendAddr   <= '0;
      pendLen    <= '0;
      pendLast   <= 1'b0;
      count      <= '0;
      lastCnt    <= '0;
    end else begin
      if (stb.takeSeg) begin
        if (haveRegion) begin
          regSize <= regSize + segLen32;
        end else begin
          regAddr    <= segAddr;
          regSize    <= segLen32;
          haveRegion <= 1'b1;
        end
      end
      if (stb.savePend) begin
        pendAddr <= segAddr;
        pendLen  <= segLen32;
        pendLast <= segLast;
      end
      if (stb.loadPend) begin
        regAddr <= pendAddr;
        regSize <= pendLen;
      end
      if (stb.wrCount) begin
        regAddr <= regAddr + 32'(chunk);
        regSize <= regSize - 32'(chunk);
        count   <= count + 1'b1;
        lastCnt <= chunk[15:0];
      end
    end
  end

  always_comb begin
    st.misaligned = |segAddr[1:0];
    st.contiguous = (regAddr + regSize) == segAddr;
    st.haveRegion = haveRegion;
    st.regEmpty   = (regSize == 32'd0);
    st.atCapacity = (count == CNT_W'(CAP - 1));
    st.countZero  = (count == '0);
    st.pendLast   = pendLast;
  end

  always_comb begin
    memWe = stb.wrAddr | stb.wrCount | stb.wrEot;
    if (stb.wrEot) begin
      memAddr = {count - 1'b1, 1'b1};
      memData = {1'b1, 15'd0, lastCnt};
    end else if (stb.wrCount) begin
      memAddr = {count, 1'b1};
      memData = {16'd0, chunk[15:0]};
    end else begin
      memAddr = {count, 1'b0};
      memData = regAddr;
    end
  end

  assign entryCount = count;
endmodule

// File: rtl/sg_table_gen.sv
module sg_table_gen
  import sg_pkg::*;
#(
  parameter int LEN_W         = 24,
  parameter int TABLE_ENTRIES = 256,
  parameter int CNT_W         = $clog2(TABLE_ENTRIES),
  parameter int AW            = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segValid,
  output logic             segReady,
  input  logic [31:0]      segAddr,
  input  logic [LEN_W-1:0] segLen,
  input  logic             segLast,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memData,
  output logic             done,
  output logic [CNT_W-1:0] entryCount,
  output logic             fail,
  output logic [1:0]       failCode
);
  sg_strobe_t stb;
  sg_status_t st;

  sg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .segValid(segValid), .segLast(segLast),
    .st(st), .stb(stb), .segReady(segReady), .done(done),
    .fail(fail), .failCode(failCode)
  );

  sg_datapath #(.LEN_W(LEN_W), .CAP(TABLE_ENTRIES), .CNT_W(CNT_W), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .segAddr(segAddr), .segLen(segLen),
    .segLast(segLast), .st(st), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .entryCount(entryCount)
  );
endmodule

// File: rtl/sg_table_gen_chk.sv
module sg_table_gen_chk #(
  parameter int TABLE_ENTRIES = 256,
  parameter int CNT_W         = $clog2(TABLE_ENTRIES),
  parameter int AW            = CNT_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             memWe,
  input logic [AW-1:0]    memAddr,
  input logic [31:0]      memData,
  input logic             done,
  input logic [CNT_W-1:0] entryCount,
  input logic             fail,
  input logic [1:0]       failCode
);
  logic [AW-1:0] wordCnt;
  logic [15:0]   lastBaseLow;
  logic [16:0]   span;

  assign span = (memData[15:0] == 16'd0) ? 17'h10000 : {1'b0, memData[15:0]};

  always_ff @(posedge clk) begin
    if (!rstN || done || fail) begin
      wordCnt     <= '0;
      lastBaseLow <= '0;
    end else if (memWe && !memData[31]) begin
      wordCnt <= wordCnt + 1'b1;
      if (!memAddr[0]) lastBaseLow <= memData[15:0];
    end
  end

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    memWe && !memData[31] |-> memAddr == wordCnt); // R1
  AST_COUNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    memWe && memAddr[0] |-> memData[30:16] == 15'd0); // R1
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    memWe && memAddr[0] && !memData[31] |-> {1'b0, lastBaseLow} + span <= 17'h10000); // R3
  AST_EOT_PLACE: assert property (@(posedge clk) disable iff (!rstN)
    memWe && memData[31] |-> memAddr[0] && (memAddr == wordCnt - 1'b1)); // R5
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memWe && !memAddr[0] |-> memData[1:0] == 2'b00); // R6
  AST_TABLE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr < AW'(2 * (TABLE_ENTRIES - 1))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !fail && entryCount != '0 && {entryCount, 1'b0} == wordCnt); // R9
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> failCode != 2'd0); // R8
endmodule

bind sg_table_gen sg_table_gen_chk #(.TABLE_ENTRIES(TABLE_ENTRIES), .CNT_W(CNT_W), .AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memData(memData),
  .done(done), .entryCount(entryCount), .fail(fail), .failCode(failCode)
);

// File: tb/sg_table_gen_test.sv
module sg_table_gen_test;
  localparam int CAP = 16;
  localparam int LW  = 24;
  localparam int CW  = $clog2(CAP);
  localparam int AW  = CW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic segValid = 1'b0, segLast = 1'b0;
  logic segReady, memWe, done, fail;
  logic [31:0] segAddr = '0, memData;
  logic [LW-1:0] segLen = '0;
  logic [AW-1:0] memAddr;
  logic [CW-1:0] entryCount;
  logic [1:0] failCode;

  always #5 clk = ~clk;

  sg_table_gen #(.LEN_W(LW), .TABLE_ENTRIES(CAP)) uut (
    .clk(clk), .rstN(rstN), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .segLast(segLast), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .done(done), .entryCount(entryCount),
    .fail(fail), .failCode(failCode)
  );

  int nChecks = 0, nErr = 0;
  logic [31:0] tbl [0:2*CAP-1];
  logic [31:0] segA [0:7];
  logic [31:0] segL [0:7];
  logic [31:0] expW [0:2*CAP-1];
  int expCount, expCode;
  int accCnt, doneCnt, failCnt, gotCount, gotCode;

  always @(posedge clk) begin
    if (memWe) tbl[memAddr] <= memData;
    if (segValid && segReady) accCnt <= accCnt + 1;
    if (done) begin doneCnt <= doneCnt + 1; gotCount <= int'(entryCount); end
    if (fail) begin failCnt <= failCnt + 1; gotCode <= int'(failCode); end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference table builder, written from the requirements
  task automatic modelReq(input int n);
    logic [31:0] ra, rs, a, chunk;
    bit have;
    int c;
    have = 0; ra = 0; rs = 0; c = 0; expCode = 0;
    for (int i = 0; i <= n; i++) begin
      if (i < n) begin
        if (segA[i][1:0] != 2'b00) begin expCode = 1; expCount = c; return; end
        if (have && (ra + rs == segA[i])) begin rs = rs + segL[i]; continue; end
      end
      if (have) begin
        a = ra;
        while (rs != 0) begin
          if (c >= CAP - 1) begin expCode = 2; expCount = c; return; end
          chunk = 32'h10000 - {16'd0, a[15:0]};
          if (rs < chunk) chunk = rs;
          expW[2*c]   = a;
          expW[2*c+1] = {16'd0, chunk[15:0]};
          c++; a = a + chunk; rs = rs - chunk;
        end
      end
      if (i < n) begin ra = segA[i]; rs = segL[i]; have = 1; end
    end
    expCount = c;
    if (c == 0) expCode = 3;
    else expW[2*c-1][31] = 1'b1;
  endtask

  task automatic runReq(input int n, input string tag);
    int early;
    modelReq(n);
    @(negedge clk);
    accCnt = 0; doneCnt = 0; failCnt = 0; gotCount = -1; gotCode = -1; early = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = int'($urandom % 3); g > 0; g--) @(negedge clk);
      if (i == n - 1) early = doneCnt + failCnt;
      segValid = 1'b1; segAddr = segA[i]; segLen = segL[i][LW-1:0]; segLast = (i == n - 1);
      forever begin
        if (segReady) begin @(negedge clk); break; end
        @(negedge clk);
      end
      segValid = 1'b0; segLast = 1'b0;
    end
    for (int w = 0; w < 4 * CAP + 10 && doneCnt + failCnt == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(early == 0, {tag, " R10 early status"}, early, 0);
    chk(accCnt == n, {tag, " R11 accepted segments"}, accCnt, n);
    if (expCode == 0) begin
      chk(doneCnt == 1 && failCnt == 0, {tag, " R9 done pulse"}, doneCnt, 1);
      chk(gotCount == expCount, {tag, " R9 entry count"}, gotCount, expCount);
      for (int k = 0; k < 2 * expCount; k++) begin
        chk(tbl[k] === expW[k], {tag, " R1 table word"}, tbl[k], expW[k]);
        if (k[0]) chk(tbl[k][31] === (k == 2*expCount-1), {tag, " R5 end bit"}, tbl[k], expW[k]);
      end
    end else begin
      chk(failCnt == 1 && doneCnt == 0, {tag, " R8 fail pulse"}, failCnt, 1);
      chk(gotCode == expCode, {tag, " R6 R7 R8 fail code"}, gotCode, expCode);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(segReady && !done && !fail && !memWe, "R11 reset state", {segReady, done, fail, memWe}, 4'b1000);

    segA[0] = 32'h0000_1000; segL[0] = 32'h200;                 runReq(1, "R1 single");
    segA[0] = 32'h0002_0000; segL[0] = 32'h100;
    segA[1] = 32'h0002_0100; segL[1] = 32'h300;                 runReq(2, "R2 merge");
    segA[0] = 32'h0001_0000; segL[0] = 32'h40;
    segA[1] = 32'h0005_0000; segL[1] = 32'h80;
    segA[2] = 32'h0005_0080; segL[2] = 32'h20;                  runReq(3, "R2 split regions");
    segA[0] = 32'h0000_FFF0; segL[0] = 32'h20;                  runReq(1, "R3 crossing");
    segA[0] = 32'h0003_0000; segL[0] = 32'h10000;               runReq(1, "R4 full chunk");
    segA[0] = 32'h0000_8000; segL[0] = 32'h18000;               runReq(1, "R4 two chunks");
    segA[0] = 32'h0000_1002; segL[0] = 32'h10;                  runReq(1, "R6 misaligned");
    segA[0] = 32'h0000_2001; segL[0] = 32'h10;
    segA[1] = 32'h0000_4000; segL[1] = 32'h10;
    segA[2] = 32'h0000_5000; segL[2] = 32'h10;                  runReq(3, "R10 drain");
    segA[0] = 32'h0000_0000; segL[0] = 32'h100000;              runReq(1, "R7 overflow");
    segA[0] = 32'h0000_0000; segL[0] = 32'h0F0000;              runReq(1, "R7 at limit");
    segA[0] = 32'h0000_0000; segL[0] = 32'h080000;
    segA[1] = 32'h0010_0000; segL[1] = 32'h080000;
    segA[2] = 32'h0030_0000; segL[2] = 32'h10;                  runReq(3, "R7 overflow drain");
    segA[0] = 32'h0000_4000; segL[0] = 32'h0;                   runReq(1, "R8 empty");
    segA[0] = 32'h0000_4000; segL[0] = 32'h0;
    segA[1] = 32'h0000_9000; segL[1] = 32'h0;                   runReq(2, "R8 empty pair");

    for (int r = 0; r < 25; r++) begin
      int n;
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) begin
        if (i > 0 && ($urandom % 3) == 0) segA[i] = segA[i-1] + segL[i-1];
        else segA[i] = $urandom & 32'h003F_FFFC;
        if (($urandom % 12) == 0) segA[i][0] = 1'b1;
        segL[i] = ($urandom % 32'h14000) & 32'hFFFF_FFFC;
      end
      runReq(n, "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule